// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns activity on one active-low external interrupt pin into a pending-request latch. It raises a CPU interrupt request from that latch. Software reaches the latch through one byte-wide status/control register at byte address 0x1E. The register bus is a simple one: an address, a write strobe, write data and combinational read data. From this register software reads the pending flag, sets the request mask, selects the trigger sensitivity, and clears the latch by writing a one to a self-clearing acknowledge bit. The CPU can also clear the latch by pulsing the interrupt-acknowledge input during its vector fetch.

The pin first passes through a two-flop synchronizer, and a falling edge detector follows it. A small state machine holds the request. It has two states, `ST_IDLE` and `ST_PEND`.
- `ST_IDLE -> ST_PEND` happens on a detected falling edge.
- `ST_PEND -> ST_IDLE` happens on an accepted clear when no new edge arrives in the same cycle. In edge-and-level mode, the pin must also be high.
- Every other case holds the current state.

While a debug break is active, software acknowledges are discarded unless the break-clear-enable input is high.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and `cpu_irq` is 0.
- R2: At address 0x1E, bit 1 reads back the mask and bit 0 reads back the mode (0 = edge only, 1 = edge and level). Bits 7..4 and bit 2 always read 0. Any other address reads 0x00.
- R3: A high-to-low pin transition sets the flag in bit 3. The flag becomes visible on the third rising clock edge after the pin change. A low-to-high transition never sets it.
- R4: Outside break, a write to 0x1E with bit 2 = 1 clears the flag. A write with bit 2 = 0 leaves it unchanged.
- R5: `cpu_irq` is 1 exactly when the flag is 1 and the mask is 0. A mask of 1 does not stop the flag from setting or reading as 1.
- R6: While `brk_active` = 1 and `brk_clr_en` = 0, an acknowledge write leaves the flag set. The flag is still set after the break ends.
- R7: While `brk_active` = 1 and `brk_clr_en` = 1, an acknowledge write clears the flag. The flag stays clear after the break ends.
- R8: In mode 1, a clear has no effect while the synchronized pin is low, and works again once the pin is high. In mode 0, a clear works with the pin low.
- R9: A one-cycle `cpu_iack` pulse clears the flag under the same mode rule as R8. It is not gated by the break inputs.
- R10: If a falling edge is detected in the same cycle as a clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| brk_active | input | 1 | Debug break state is active |
| brk_clr_en | input | 1 | Allows software acknowledges during break |
| cpu_iack | input | 1 | Interrupt-acknowledge (vector fetch) pulse |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The embedded properties assume several things about the inputs:
- `bus_wr` pulses for a single cycle per access.
- `cpu_iack` is a single-cycle pulse.
- `brk_active` and `brk_clr_en` are stable around each write they qualify.

The bench drives every input on the falling clock edge and holds each write strobe for exactly one cycle. It changes the break inputs only between accesses. It waits at least four cycles after each pin transition before issuing a clear, except in the one scenario that deliberately lines up an edge with a clear.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } latch_state_t;

    localparam int BIT_MODE = 0;
    localparam int BIT_MASK = 1;
    localparam int BIT_ACK  = 2;
    localparam int BIT_FLAG = 3;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_low,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[LAST:0], pin_n};
        end
    end

    assign pin_low = ~chain[LAST];
    assign fall    = chain[STAGES] & ~chain[LAST];
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic pin_low,
    input  logic mode,
    input  logic sw_ack,
    input  logic brk,
    input  logic brk_clr_en,
    input  logic iack,
    output logic flag
);
    latch_state_t state_q, state_d;
    logic sw_clr_ok;
    logic clr_req;
    logic clr_go;

    assign sw_clr_ok = sw_ack & (~brk | brk_clr_en);
    assign clr_req   = sw_clr_ok | iack;
    assign clr_go    = clr_req & ~(mode & pin_low) & ~fall;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fall)   state_d = ST_PEND;
            ST_PEND: if (clr_go) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == ST_PEND);
    end

    // R3: a detected edge always leaves the latch pending
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> flag);

    // R6: acknowledge in protected break cannot clear
    a_r6_brk_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && sw_ack && brk && !brk_clr_en && !iack) |=> flag);

    // R7: acknowledge in break with clear enable clears
    a_r7_brk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && sw_ack && brk && brk_clr_en && !fall && !pin_low) |=> !flag);

    // R8: level mode holds the latch while the pin is low
    a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && mode && pin_low) |=> flag);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int            ADDR_W   = 8,
    parameter int            DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output logic [DATA_W-1:0] rdata,
    output logic              mask,
    output logic              mode,
    output logic              ack_wr
);
    logic sel;

    assign sel    = (addr == REG_ADDR);
    assign ack_wr = wr & sel & wdata[BIT_ACK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= 1'b0;
            mode <= 1'b0;
        end else if (wr && sel) begin
            mask <= wdata[BIT_MASK];
            mode <= wdata[BIT_MODE];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[BIT_FLAG] = flag;
            rdata[BIT_MASK] = mask;
            rdata[BIT_MODE] = mode;
        end
    end

    // R2: acknowledge bit and upper bits never read back
    always_comb begin
        if (rst_n) a_r2_ack_reads_zero: assert (rdata[BIT_ACK] == 1'b0);
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              brk_active,
    input  logic              brk_clr_en,
    input  logic              cpu_iack,
    output logic              cpu_irq
);
    logic pin_low, fall, flag, mask, mode, ack_wr;

    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (irq_pin_n),
        .pin_low (pin_low),
        .fall    (fall)
    );

    ext_irq_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .pin_low    (pin_low),
        .mode       (mode),
        .sw_ack     (ack_wr),
        .brk        (brk_active),
        .brk_clr_en (brk_clr_en),
        .iack       (cpu_iack),
        .flag       (flag)
    );

    ext_irq_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .flag   (flag),
        .rdata  (bus_rdata),
        .mask   (mask),
        .mode   (mode),
        .ack_wr (ack_wr)
    );

    assign cpu_irq = flag & ~mask;

    // R5: a set mask keeps the CPU request low
    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !cpu_irq);
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic [7:0] bus_addr = 8'h1E;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       brk_active = 1'b0;
    logic       brk_clr_en = 1'b0;
    logic       cpu_iack = 1'b0;
    logic       cpu_irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ext_irq_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pin_n  (irq_pin_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .brk_active (brk_active),
        .brk_clr_en (brk_clr_en),
        .cpu_iack   (cpu_iack),
        .cpu_irq    (cpu_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        bus_addr  = 8'h1E;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] exp);
        bus_addr = 8'h1E;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic pin_pulse();
        @(negedge clk) irq_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        irq_pin_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 reg", 8'h00);
        check("R1 irq", {7'b0, cpu_irq}, 8'h00);
    endtask

    task automatic t_regmap();
        wr_reg(8'hFB);
        rd_chk("R2 mask/mode", 8'h03);
        bus_addr = 8'h1F;
        #0.5;
        check("R2 other addr", bus_rdata, 8'h00);
        wr_reg(8'h00);
        rd_chk("R2 cleared", 8'h00);
    endtask

    task automatic t_edge_set();
        @(negedge clk) irq_pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R3 not yet", 8'h00);
        @(negedge clk);
        rd_chk("R3 set", 8'h08);
        check("R5 irq", {7'b0, cpu_irq}, 8'h01);
        wr_reg(8'h04);
        rd_chk("R8 mode0 clear with pin low", 8'h00);
        @(negedge clk) irq_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R3 rising ignored", 8'h00);
    endtask

    task automatic t_sw_ack();
        pin_pulse();
        wr_reg(8'h00);
        rd_chk("R4 ack0 keeps", 8'h08);
        wr_reg(8'h04);
        rd_chk("R4 ack1 clears", 8'h00);
    endtask

    task automatic t_mask();
        wr_reg(8'h02);
        pin_pulse();
        rd_chk("R5 masked flag", 8'h0A);
        check("R5 masked irq", {7'b0, cpu_irq}, 8'h00);
        wr_reg(8'h00);
        check("R5 unmasked irq", {7'b0, cpu_irq}, 8'h01);
        wr_reg(8'h04);
        check("R5 irq after clear", {7'b0, cpu_irq}, 8'h00);
    endtask

    task automatic t_brk_protect();
        pin_pulse();
        @(negedge clk) begin brk_active = 1'b1; brk_clr_en = 1'b0; end
        wr_reg(8'h04);
        rd_chk("R6 protected", 8'h08);
        @(negedge clk) brk_active = 1'b0;
        @(negedge clk);
        rd_chk("R6 after break", 8'h08);
        wr_reg(8'h04);
        rd_chk("R4 clear after break", 8'h00);
    endtask

    task automatic t_brk_clear();
        pin_pulse();
        @(negedge clk) begin brk_active = 1'b1; brk_clr_en = 1'b1; end
        wr_reg(8'h04);
        rd_chk("R7 cleared in break", 8'h00);
        @(negedge clk) begin brk_active = 1'b0; brk_clr_en = 1'b0; end
        repeat (3) @(negedge clk);
        rd_chk("R7 stays clear", 8'h00);
    endtask

    task automatic t_level();
        wr_reg(8'h01);
        @(negedge clk) irq_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R8 set", 8'h09);
        wr_reg(8'h05);
        rd_chk("R8 held while low", 8'h09);
        @(negedge clk) irq_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        wr_reg(8'h05);
        rd_chk("R8 clears when high", 8'h01);
    endtask

    task automatic t_iack();
        @(negedge clk) irq_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        @(negedge clk) cpu_iack = 1'b1;
        @(negedge clk) cpu_iack = 1'b0;
        rd_chk("R9 iack held in mode1", 8'h09);
        @(negedge clk) irq_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        @(negedge clk) cpu_iack = 1'b1;
        @(negedge clk) cpu_iack = 1'b0;
        rd_chk("R9 iack clears mode1", 8'h01);
        wr_reg(8'h00);
        pin_pulse();
        @(negedge clk) begin cpu_iack = 1'b1; brk_active = 1'b1; end
        @(negedge clk) begin cpu_iack = 1'b0; brk_active = 1'b0; end
        rd_chk("R9 iack clears mode0", 8'h00);
    endtask

    task automatic t_priority();
        pin_pulse();
        @(negedge clk) irq_pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_addr  = 8'h1E;
        bus_wdata = 8'h04;
        bus_wr    = 1'b1;
        @(negedge clk) bus_wr = 1'b0;
        rd_chk("R10 edge beats clear", 8'h08);
        @(negedge clk) irq_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        wr_reg(8'h04);
        rd_chk("R10 cleanup", 8'h00);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #20000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_edge_set();
        t_sw_ack();
        t_mask();
        t_brk_protect();
        t_brk_clear();
        t_level();
        t_iack();
        t_priority();
        finish_run();
    end
endmodule